// File: doc/BRIEF.md
# Delayed-Write Parity Error Reporter

This block belongs to a two-port bus bridge. It decides how a parity error is reported when a delayed write completes, in either direction. The primary side is the initiator of downstream writes, and the secondary side is the initiator of upstream writes. Each side handles its own accepted data phases:

- The block raises that side's target-ready strobe one cycle after the data phase is presented.
- It tells the delayed-transaction queue whether to keep the write or retire its status.
- Where the enables allow, it pulses that side's active-low parity error line a fixed number of cycles (two by default) after target-ready.

Two kinds of error are handled, and they are treated differently:

- A local error is one seen on the initiator bus itself. It means data and parity did not match the queued request. The write stays queued, the side's sticky detected flag is set, and the pulse depends only on that side's own response enable.
- A forwarded error is one passed back from the target bus, with no local error in the same phase. The write completes and retires normally. The pulse requires both response enables to be set.

Each error pulse is held in a delay pipeline. A new phase can therefore arrive every cycle without losing the pulse of an earlier one.

Top module: `br_perr_reporter`

## Requirements
- R1: During and right after reset, `trdy`, `keep_req`, `retire_req` and `perr_det` are all 0 and `perr_n` is all 1.
- R2: For each side s (bit 0 primary, bit 1 secondary), `trdy[s]` is 1 in exactly the cycle after a cycle with `wr_phase[s]` high. It is 0 otherwise.
- R3: For a phase with `init_perr[s]` high, `perr_n[s]` is 0 for one cycle, PERR_GAP cycles after the `trdy[s]` cycle. This happens only if the side's own enable was 1 in the phase cycle: `pri_per_en` for side 0, `sec_per_en` for side 1.
- R4: A phase with `init_perr[s]` high sets `perr_det[s]` in the `trdy[s]` cycle. The bit then stays 1.
- R5: A `det_clr[s]` pulse clears `perr_det[s]` in the next cycle. If a setting phase is sampled in the same cycle as the pulse, the set wins.
- R6: A phase with `init_perr[s]` high raises `keep_req[s]` and leaves `retire_req[s]` low in its `trdy[s]` cycle.
- R7: A phase with `fwd_perr[s]` high and `init_perr[s]` low gives the R3 pulse only when both `pri_per_en` and `sec_per_en` were 1. It does not change `perr_det[s]`.
- R8: A phase with `init_perr[s]` low raises `retire_req[s]` and leaves `keep_req[s]` low in its `trdy[s]` cycle.
- R9: A phase with neither error flag produces no `perr_n[s]` pulse.
- R10: Phases on consecutive cycles each produce their own pulse, or no pulse, in their own cycle. None is lost or merged.
- R11: The two sides run independently, including when both have phases in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_phase | input | 2 | Delayed-write data phase with status ready, per side |
| init_perr | input | 2 | Parity error seen on the initiator bus in this phase |
| fwd_perr | input | 2 | Parity error returned from the target bus with this status |
| pri_per_en | input | 1 | Primary parity-error-response enable |
| sec_per_en | input | 1 | Secondary parity-error-response enable |
| det_clr | input | 2 | Write-one-to-clear pulse for the detected flags |
| trdy | output | 2 | Target-ready strobe per side |
| perr_n | output | 2 | Active-low parity error pulse per side |
| perr_det | output | 2 | Sticky parity-error-detected flags |
| keep_req | output | 2 | Leave the delayed write queued |
| retire_req | output | 2 | Retire the delayed write status |

## Verification
The assertions assume three things about the inputs:
- Each input is held steady across a clock edge.
- The enables in force for a phase are the values present in that phase's own cycle.
- Error flags matter only in a cycle with `wr_phase` high.

The bench drives every input on the falling edge, so each value is settled before the rising edge that samples it. Its reference model likewise reads the enables only in the phase cycle. The random segment raises error flags without `wr_phase` as well, to show that such flags have no effect.

// File: rtl/br_perr_pkg.sv
package br_perr_pkg;

    localparam int NSIDE    = 2;
    localparam int SIDE_PRI = 0;
    localparam int SIDE_SEC = 1;

    // How a presented data phase is classified
    typedef enum logic [1:0] {
        PH_NONE  = 2'd0,
        PH_CLEAN = 2'd1,
        PH_LOCAL = 2'd2,
        PH_FWD   = 2'd3
    } phase_kind_e;

    // Registered decision travelling with the target-ready cycle
    typedef struct packed {
        logic        valid;
        phase_kind_e kind;
        logic        report;
    } phase_rsp_t;

    localparam phase_rsp_t RSP_IDLE = '{valid: 1'b0, kind: PH_NONE, report: 1'b0};

    // A local error outranks a forwarded one in the same phase
    function automatic phase_kind_e classify(input logic wr,
                                             input logic init_err,
                                             input logic fwd_err);
        phase_kind_e k;
        if (!wr)          k = PH_NONE;
        else if (init_err) k = PH_LOCAL;
        else if (fwd_err)  k = PH_FWD;
        else               k = PH_CLEAN;
        return k;
    endfunction

    // Whether the error of this phase may drive the parity error line
    function automatic logic report_allowed(input phase_kind_e k,
                                            input logic own_en,
                                            input logic pri_en,
                                            input logic sec_en);
        logic r;
        case (k)
            PH_LOCAL: r = own_en;
            PH_FWD:   r = pri_en & sec_en;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic keeps_entry(input phase_rsp_t r);
        return r.valid && (r.kind == PH_LOCAL);
    endfunction

    function automatic logic retires_entry(input phase_rsp_t r);
        return r.valid && (r.kind != PH_LOCAL);
    endfunction

endpackage

// File: rtl/br_perr_decide.sv
module br_perr_decide
    import br_perr_pkg::*;
#(
    parameter int SIDE = SIDE_PRI
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic       init_err,
    input  logic       fwd_err,
    input  logic       pri_en,
    input  logic       sec_en,
    output phase_rsp_t rsp_q
);

    phase_rsp_t  rsp_d;
    phase_kind_e kind;
    logic        own_en;

    // Each side answers to its own interface enable for local errors
    generate
        if (SIDE == SIDE_SEC) begin : g_own_sec
            assign own_en = sec_en;
        end else begin : g_own_pri
            assign own_en = pri_en;
        end
    endgenerate

    always_comb begin
        kind         = classify(wr, init_err, fwd_err);
        rsp_d.valid  = wr;
        rsp_d.kind   = kind;
        rsp_d.report = report_allowed(kind, own_en, pri_en, sec_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= RSP_IDLE;
        end else begin
            rsp_q <= rsp_d;
        end
    end

endmodule

// File: rtl/br_perr_delay.sv
module br_perr_delay #(
    parameter int GAP = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic fire
);

    // One bit per cycle of delay; back-to-back requests occupy
    // consecutive slots, so every request keeps its own pulse.
    generate
        if (GAP == 0) begin : g_direct
            assign fire = req;
        end else begin : g_pipe
            logic [GAP-1:0] slot;
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot <= '0;
                end else begin
                    slot[0] <= req;
                    for (int i = 1; i < GAP; i++) begin
                        slot[i] <= slot[i-1];
                    end
                end
            end
            assign fire = slot[GAP-1];
        end
    endgenerate

endmodule

// File: rtl/br_perr_sticky.sv
module br_perr_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    // Setting has priority so a coincident clear cannot hide an error
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/br_perr_reporter.sv
module br_perr_reporter
    import br_perr_pkg::*;
#(
    parameter int PERR_GAP = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSIDE-1:0] wr_phase,
    input  logic [NSIDE-1:0] init_perr,
    input  logic [NSIDE-1:0] fwd_perr,
    input  logic             pri_per_en,
    input  logic             sec_per_en,
    input  logic [NSIDE-1:0] det_clr,
    output logic [NSIDE-1:0] trdy,
    output logic [NSIDE-1:0] perr_n,
    output logic [NSIDE-1:0] perr_det,
    output logic [NSIDE-1:0] keep_req,
    output logic [NSIDE-1:0] retire_req
);

    phase_rsp_t       rsp [NSIDE];
    logic [NSIDE-1:0] fire;
    logic [NSIDE-1:0] det_set;

    generate
        for (genvar s = 0; s < NSIDE; s++) begin : g_side
            br_perr_decide #(.SIDE(s)) u_decide (
                .clk      (clk),
                .rst      (rst),
                .wr       (wr_phase[s]),
                .init_err (init_perr[s]),
                .fwd_err  (fwd_perr[s]),
                .pri_en   (pri_per_en),
                .sec_en   (sec_per_en),
                .rsp_q    (rsp[s])
            );

            br_perr_delay #(.GAP(PERR_GAP)) u_delay (
                .clk  (clk),
                .rst  (rst),
                .req  (rsp[s].valid & rsp[s].report),
                .fire (fire[s])
            );

            // Only initiator-side errors mark the interface status
            assign det_set[s] = wr_phase[s] & init_perr[s];

            br_perr_sticky u_sticky (
                .clk  (clk),
                .rst  (rst),
                .set  (det_set[s]),
                .clr  (det_clr[s]),
                .flag (perr_det[s])
            );

            assign trdy[s]       = rsp[s].valid;
            assign keep_req[s]   = keeps_entry(rsp[s]);
            assign retire_req[s] = retires_entry(rsp[s]);
            assign perr_n[s]     = ~fire[s];
        end
    endgenerate

endmodule

// File: rtl/br_perr_reporter_chk.sv
module br_perr_reporter_chk
    import br_perr_pkg::*;
#(
    parameter int PERR_GAP = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [NSIDE-1:0] wr_phase,
    input logic [NSIDE-1:0] init_perr,
    input logic [NSIDE-1:0] det_clr,
    input logic [NSIDE-1:0] trdy,
    input logic [NSIDE-1:0] perr_n,
    input logic [NSIDE-1:0] perr_det,
    input logic [NSIDE-1:0] keep_req,
    input logic [NSIDE-1:0] retire_req
);

    localparam int HW = (PERR_GAP < 1) ? 1 : PERR_GAP;

    generate
        for (genvar s = 0; s < NSIDE; s++) begin : g_chk
            // History of target-ready, one bit per cycle of the gap
            logic [HW-1:0] trdy_hist;
            always_ff @(posedge clk) begin
                if (rst) begin
                    trdy_hist <= '0;
                end else begin
                    trdy_hist[0] <= trdy[s];
                    for (int i = 1; i < HW; i++) begin
                        trdy_hist[i] <= trdy_hist[i-1];
                    end
                end
            end

            assert_trdy_follows_phase_R2: assert property (@(posedge clk) disable iff (rst)
                trdy[s] |-> $past(wr_phase[s]));

            assert_phase_gives_trdy_R2: assert property (@(posedge clk) disable iff (rst)
                wr_phase[s] |=> trdy[s]);

            if (PERR_GAP >= 1) begin : g_gap
                assert_perr_after_trdy_R3: assert property (@(posedge clk) disable iff (rst)
                    !perr_n[s] |-> trdy_hist[HW-1]);
            end

            assert_det_rise_cause_R4: assert property (@(posedge clk) disable iff (rst)
                $rose(perr_det[s]) |-> $past(wr_phase[s] & init_perr[s]));

            assert_det_fall_cause_R5: assert property (@(posedge clk) disable iff (rst)
                $fell(perr_det[s]) |-> $past(det_clr[s]));

            assert_keep_retire_excl_R6: assert property (@(posedge clk) disable iff (rst)
                trdy[s] |-> (keep_req[s] ^ retire_req[s]));

            assert_no_strobe_idle_R8: assert property (@(posedge clk) disable iff (rst)
                !trdy[s] |-> !(keep_req[s] | retire_req[s]));

            assert_keep_marks_det_R6: assert property (@(posedge clk) disable iff (rst)
                keep_req[s] |-> perr_det[s]);
        end
    endgenerate

endmodule

bind br_perr_reporter br_perr_reporter_chk #(.PERR_GAP(PERR_GAP)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_phase   (wr_phase),
    .init_perr  (init_perr),
    .det_clr    (det_clr),
    .trdy       (trdy),
    .perr_n     (perr_n),
    .perr_det   (perr_det),
    .keep_req   (keep_req),
    .retire_req (retire_req)
);

// File: tb/br_perr_reporter_tb.sv
module br_perr_reporter_tb;

    localparam int GAP = 2;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] wr_phase, init_perr, fwd_perr, det_clr;
    logic       pri_per_en, sec_per_en;
    logic [1:0] trdy, perr_n, perr_det, keep_req, retire_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string tag = "R1";

    // Reference state
    logic [1:0] e_trdy, e_perr_n, e_det, e_keep, e_ret;
    int q0[$];
    int q1[$];

    always #2 clk = ~clk;

    br_perr_reporter #(.PERR_GAP(GAP)) u_dut (
        .clk(clk), .rst(rst), .wr_phase(wr_phase), .init_perr(init_perr),
        .fwd_perr(fwd_perr), .pri_per_en(pri_per_en), .sec_per_en(sec_per_en),
        .det_clr(det_clr), .trdy(trdy), .perr_n(perr_n), .perr_det(perr_det),
        .keep_req(keep_req), .retire_req(retire_req)
    );

    // Behavioural model: a phase at edge k is answered after edge k,
    // and its pulse (if any) appears after edge k+GAP.
    always @(posedge clk) begin
        if (rst) begin
            e_trdy = 0; e_perr_n = 2'b11; e_det = 0; e_keep = 0; e_ret = 0;
            q0.delete(); q1.delete();
            cyc = 0;
        end else begin
            cyc++;
            for (int s = 0; s < 2; s++) begin
                bit own, rep;
                own = (s == 0) ? pri_per_en : sec_per_en;
                rep = 0;
                if (wr_phase[s]) begin
                    if (init_perr[s]) rep = own;
                    else if (fwd_perr[s]) rep = pri_per_en && sec_per_en;
                end
                e_trdy[s] = wr_phase[s];
                e_keep[s] = wr_phase[s] && init_perr[s];
                e_ret[s]  = wr_phase[s] && !init_perr[s];
                if (wr_phase[s] && init_perr[s]) e_det[s] = 1;
                else if (det_clr[s]) e_det[s] = 0;
                e_perr_n[s] = 1;
                if (s == 0) begin
                    if (q0.size() > 0 && q0[0] == cyc) begin e_perr_n[s] = 0; void'(q0.pop_front()); end
                    if (rep) q0.push_back(cyc + GAP);
                end else begin
                    if (q1.size() > 0 && q1[0] == cyc) begin e_perr_n[s] = 0; void'(q1.pop_front()); end
                    if (rep) q1.push_back(cyc + GAP);
                end
            end
        end
    end

    task automatic chk(input string what, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("trdy", trdy, e_trdy);
            chk("perr_n", perr_n, e_perr_n);
            chk("perr_det", perr_det, e_det);
            chk("keep_req", keep_req, e_keep);
            chk("retire_req", retire_req, e_ret);
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_phase = 0; init_perr = 0; fwd_perr = 0; det_clr = 0;
        end
    endtask

    task automatic phase(input logic [1:0] wr, input logic [1:0] ie,
                         input logic [1:0] fe, input logic [1:0] clr);
        @(negedge clk);
        wr_phase = wr; init_perr = ie; fwd_perr = fe; det_clr = clr;
    endtask

    initial begin
        rst = 1; wr_phase = 0; init_perr = 0; fwd_perr = 0; det_clr = 0;
        pri_per_en = 1; sec_per_en = 1;
        repeat (3) @(negedge clk);
        // R1: outputs held at rest during reset
        chk("reset trdy", trdy, 2'b00);
        chk("reset perr_n", perr_n, 2'b11);
        chk("reset perr_det", perr_det, 2'b00);
        chk("reset keep", keep_req, 2'b00);
        chk("reset retire", retire_req, 2'b00);
        rst = 0;
        idle(2);

        // R2 / R3 / R4 / R6: local error on primary, enable on
        tag = "R3";
        phase(2'b01, 2'b01, 2'b00, 2'b00);
        idle(5);
        // R5: clear, then set and clear together
        tag = "R5";
        phase(2'b00, 2'b00, 2'b00, 2'b01);
        idle(2);
        phase(2'b01, 2'b01, 2'b00, 2'b00);
        phase(2'b01, 2'b01, 2'b00, 2'b01);
        idle(4);
        phase(2'b00, 2'b00, 2'b00, 2'b01);
        idle(2);

        // R3: local error with own enable off still keeps and marks
        tag = "R4";
        pri_per_en = 0;
        phase(2'b01, 2'b01, 2'b00, 2'b00);
        idle(4);
        pri_per_en = 1; sec_per_en = 0;
        tag = "R6";
        phase(2'b10, 2'b10, 2'b00, 2'b00);
        idle(4);
        sec_per_en = 1;
        phase(2'b10, 2'b10, 2'b00, 2'b00);
        idle(4);
        phase(2'b00, 2'b00, 2'b00, 2'b11);
        idle(2);

        // R7: forwarded errors need both enables
        tag = "R7";
        phase(2'b11, 2'b00, 2'b11, 2'b00);
        idle(4);
        pri_per_en = 0;
        phase(2'b11, 2'b00, 2'b11, 2'b00);
        idle(4);
        pri_per_en = 1; sec_per_en = 0;
        phase(2'b11, 2'b00, 2'b11, 2'b00);
        idle(4);
        sec_per_en = 1;

        // R8 / R9: clean phases retire with no pulse
        tag = "R9";
        phase(2'b11, 2'b00, 2'b00, 2'b00);
        phase(2'b11, 2'b00, 2'b00, 2'b00);
        idle(4);
        tag = "R8";
        phase(2'b01, 2'b10, 2'b10, 2'b00);
        idle(4);

        // R10: back-to-back phases with mixed outcomes
        tag = "R10";
        phase(2'b01, 2'b01, 2'b00, 2'b00);
        phase(2'b01, 2'b00, 2'b00, 2'b00);
        phase(2'b01, 2'b00, 2'b01, 2'b00);
        phase(2'b01, 2'b01, 2'b01, 2'b00);
        phase(2'b01, 2'b00, 2'b01, 2'b00);
        idle(5);

        // R11: both sides, random traffic and enable changes
        tag = "R11";
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            wr_phase  = 2'($urandom_range(0, 3));
            init_perr = {($urandom_range(0, 4) == 0), ($urandom_range(0, 4) == 0)};
            fwd_perr  = {($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0)};
            det_clr   = {($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0)};
            if ($urandom_range(0, 15) == 0) pri_per_en = ~pri_per_en;
            if ($urandom_range(0, 15) == 0) sec_per_en = ~sec_per_en;
        end
        idle(6);
        finish_run();
    end

endmodule